// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Transceiver

This block sends and receives asynchronous serial frames that carry nine data bits and no parity. A frame opens with a low start bit and closes with one or two high stop bits. The eight low data bits travel through byte-wide transmit and receive ports. The ninth bit has its own transmit input and its own receive output. Software can therefore use the ninth bit as an address-or-data marker, or treat it as ordinary payload.

Bit timing comes from an external baud generator. That generator supplies an enable pulse at sixteen times the bit rate, and every bit lasts sixteen of those pulses. The transmitter takes a byte, a ninth bit and a stop-bit count through a one-cycle load strobe. It holds a busy flag while the frame is on the line. The receiver synchronises the incoming line and looks for a falling edge. It confirms the start bit at mid-bit, then samples each later bit at its centre. It delivers each frame with a one-cycle valid pulse and a framing-error flag.

Top module: `nine_bit_uart`

## Requirements
- R1: During and right after reset, `txd` is 1, `tx_busy` is 0, `rx_valid` is 0 and `rx_frame_err` is 0.
- R2: A transmitted frame is a 0 start bit, then `tx_byte` bit 0 first through bit 7, then `tx_bit9`, then high stop bits. Each bit lasts exactly 16 `tick` pulses, whatever the spacing of those pulses.
- R3: `two_stop` is sampled at load. A value of 1 gives two stop bits (12 bit periods per frame) and 0 gives one (11 bit periods).
- R4: `tx_busy` rises on the clock edge that accepts a load. It falls on the edge of the 16th tick of the final stop bit. `txd` changes only on tick edges while busy.
- R5: A `tx_load` pulse while `tx_busy` is 1 is ignored. The frame on the line and the number of frames sent are unchanged.
- R6: For each received frame, `rx_valid` pulses for exactly one cycle. In that cycle, `rx_byte` holds the eight low data bits (first received bit in bit 0) and `rx_bit9` holds the ninth bit. No parity bit is expected.
- R7: A low level on `rxd` that ends before the 8th tick after the falling edge is a false start. It produces no `rx_valid`.
- R8: If the line is low where the first stop bit is sampled, `rx_frame_err` is 1 together with `rx_valid`, and the data is still delivered. The next good frame returns `rx_frame_err` to 0.
- R9: After a frame, the receiver starts a new frame only on a high-to-low transition. A line that stays low after a framing error produces no further `rx_valid`.
- R10: The receiver accepts frames with either one or two stop bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-cycle enable at 16 times the bit rate |
| tx_load | input | 1 | Strobe that starts a frame when idle |
| tx_byte | input | 8 | Low eight data bits to send |
| tx_bit9 | input | 1 | Ninth data bit to send |
| two_stop | input | 1 | 1 selects two stop bits, 0 selects one |
| txd | output | 1 | Serial output, idle high |
| tx_busy | output | 1 | High while a frame is being sent |
| rxd | input | 1 | Serial input, asynchronous |
| rx_byte | output | 8 | Low eight bits of the last received frame |
| rx_bit9 | output | 1 | Ninth bit of the last received frame |
| rx_valid | output | 1 | One-cycle pulse when a frame is delivered |
| rx_frame_err | output | 1 | Stop bit of the last frame was sampled low |

## Verification
The receiver's error paths are the hardest states to reach, because a well-behaved transmitter never produces them. These paths are a start pulse too short to confirm, a stop bit sampled low, and a line that stays low after such an error. To reach them, the bench opens the loopback from `txd` to `rxd` and drives `rxd` by hand with bit periods counted in ticks. It drops the line for a few ticks to make a false start. It sends a frame whose stop bit is low and then holds the line low for many bit times. It then releases the line and follows with a clean frame, which must clear the error flag.

// File: rtl/nbu_pkg.sv
// Shared state encodings for the nine-bit transceiver.
// Assumes: included in compile order ahead of every nbu_* module.
package nbu_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_START = 2'd1,
        TX_DATA  = 2'd2,
        TX_STOP  = 2'd3
    } tx_state_t;

    typedef enum logic [1:0] {
        RX_IDLE  = 2'd0,
        RX_START = 2'd1,
        RX_DATA  = 2'd2,
        RX_STOP  = 2'd3
    } rx_state_t;

endpackage

// File: rtl/nbu_sync.sv
// Multi-stage synchroniser for an asynchronous single-bit input.
// Assumes: STAGES >= 1; the reset value matches the idle level of the line.
module nbu_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            // Purpose: single capture flop
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= RST_VAL;
                else        chain <= d;
            end
        end else begin : g_multi
            // Purpose: shift the input through the synchroniser chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= {STAGES{RST_VAL}};
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/nbu_tx.sv
// Frame serialiser: start bit, DATA_W+1 data bits LSB first, then one or two
// stop bits. Every bit lasts OVS tick pulses.
// Assumes: tick is a one-cycle enable; a load is accepted only while idle.
module nbu_tx
    import nbu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic              bit9,
    input  logic              two_stop,
    output logic              txd,
    output logic              busy
);

    localparam int FW    = DATA_W + 1;
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(FW);

    tx_state_t        st;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [FW-1:0]    sh;
    logic             stop2;
    logic             bit_end;

    assign bit_end = tick && (cnt == CNT_W'(OVS - 1));
    assign busy    = (st != TX_IDLE);

    // Purpose: count ticks within the current bit period
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (st == TX_IDLE) cnt <= '0;
        else if (tick)          cnt <= bit_end ? '0 : cnt + CNT_W'(1);
    end

    // Purpose: frame sequencer and registered line output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= TX_IDLE;
            idx   <= '0;
            sh    <= '0;
            stop2 <= 1'b0;
            txd   <= 1'b1;
        end else begin
            case (st)
                TX_IDLE: begin
                    if (load) begin
                        sh    <= {bit9, data};
                        stop2 <= two_stop;
                        idx   <= '0;
                        txd   <= 1'b0;
                        st    <= TX_START;
                    end
                end
                TX_START: begin
                    if (bit_end) begin
                        txd <= sh[0];
                        idx <= '0;
                        st  <= TX_DATA;
                    end
                end
                TX_DATA: begin
                    if (bit_end) begin
                        if (idx == IDX_W'(FW - 1)) begin
                            txd <= 1'b1;
                            idx <= '0;
                            st  <= TX_STOP;
                        end else begin
                            txd <= sh[1];
                            sh  <= sh >> 1;
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                TX_STOP: begin
                    if (bit_end) begin
                        if (stop2 && (idx == '0)) idx <= IDX_W'(1);
                        else                       st  <= TX_IDLE;
                    end
                end
                default: st <= TX_IDLE;
            endcase
        end
    end

    AST_TX_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> txd); // R1
    AST_TX_START_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !txd); // R2
    AST_TX_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> (busy && $stable(txd))); // R4
    AST_TX_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && load) |=> $stable(stop2)); // R5

endmodule

// File: rtl/nbu_rx.sv
// Frame deserialiser. It finds a falling edge, confirms the start bit half a
// bit later, samples DATA_W+1 bits and the first stop bit at bit centres, and
// reports the frame with a one-cycle valid pulse.
// Assumes: rx_in is already synchronised; OVS is even.
module nbu_rx
    import nbu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OVS    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_in,
    output logic [DATA_W-1:0] data_o,
    output logic              bit9_o,
    output logic              valid_o,
    output logic              ferr_o
);

    localparam int FW    = DATA_W + 1;
    localparam int HALF  = OVS / 2;
    localparam int CNT_W = $clog2(OVS);
    localparam int IDX_W = $clog2(FW);

    rx_state_t        st;
    logic [CNT_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [FW-1:0]    sh;
    logic             prev;
    logic             mid_hit;
    logic             full_hit;

    assign mid_hit  = tick && (cnt == CNT_W'(HALF - 1));
    assign full_hit = tick && (cnt == CNT_W'(OVS - 1));

    // Purpose: tick counter, restarted after start confirmation and each sample
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt <= '0;
        else if (st == RX_IDLE)              cnt <= '0;
        else if ((st == RX_START) && mid_hit) cnt <= '0;
        else if (full_hit)                   cnt <= '0;
        else if (tick)                       cnt <= cnt + CNT_W'(1);
    end

    // Purpose: line level at the previous tick, used for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)    prev <= 1'b1;
        else if (tick) prev <= rx_in;
    end

    // Purpose: receive sequencer, shift register and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= RX_IDLE;
            idx     <= '0;
            sh      <= '0;
            data_o  <= '0;
            bit9_o  <= 1'b0;
            valid_o <= 1'b0;
            ferr_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (st)
                RX_IDLE: begin
                    if (tick && prev && !rx_in) st <= RX_START;
                end
                RX_START: begin
                    if (mid_hit) begin
                        idx <= '0;
                        st  <= rx_in ? RX_IDLE : RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (full_hit) begin
                        sh <= {rx_in, sh[FW-1:1]};
                        if (idx == IDX_W'(FW - 1)) st  <= RX_STOP;
                        else                       idx <= idx + IDX_W'(1);
                    end
                end
                RX_STOP: begin
                    if (full_hit) begin
                        data_o  <= sh[DATA_W-1:0];
                        bit9_o  <= sh[FW-1];
                        ferr_o  <= !rx_in;
                        valid_o <= 1'b1;
                        st      <= RX_IDLE;
                    end
                end
                default: st <= RX_IDLE;
            endcase
        end
    end

    AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6
    AST_RX_FERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ferr_o) |-> valid_o); // R8
    AST_RX_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == RX_START) && mid_hit && rx_in) |=> (st == RX_IDLE)); // R7
    AST_RX_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st == RX_IDLE) && tick && !prev) |=> (st == RX_IDLE)); // R9

endmodule

// File: rtl/nine_bit_uart.sv
// Top level of the nine-bit transceiver: input synchroniser, transmitter and
// receiver sharing one 16x tick.
// Assumes: tick comes from an external baud generator on the clk domain.
module nine_bit_uart #(
    parameter int DATA_W      = 8,
    parameter int OVS         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              tx_load,
    input  logic [DATA_W-1:0] tx_byte,
    input  logic              tx_bit9,
    input  logic              two_stop,
    output logic              txd,
    output logic              tx_busy,
    input  logic              rxd,
    output logic [DATA_W-1:0] rx_byte,
    output logic              rx_bit9,
    output logic              rx_valid,
    output logic              rx_frame_err
);

    logic rxd_s;

    nbu_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (rxd),
        .q     (rxd_s)
    );

    nbu_tx #(.DATA_W(DATA_W), .OVS(OVS)) tx_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (tx_load),
        .data     (tx_byte),
        .bit9     (tx_bit9),
        .two_stop (two_stop),
        .txd      (txd),
        .busy     (tx_busy)
    );

    nbu_rx #(.DATA_W(DATA_W), .OVS(OVS)) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .rx_in   (rxd_s),
        .data_o  (rx_byte),
        .bit9_o  (rx_bit9),
        .valid_o (rx_valid),
        .ferr_o  (rx_frame_err)
    );

endmodule

// File: tb/nine_bit_uart_tb.sv
module nine_bit_uart_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       tx_load = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_bit9 = 1'b0;
    logic       two_stop = 1'b0;
    logic       loop_en = 1'b1;
    logic       rxd_drv = 1'b1;
    logic       rxd;
    logic       txd, tx_busy, rx_bit9, rx_valid, rx_frame_err;
    logic [7:0] rx_byte;

    int n_chk = 0;
    int n_err = 0;
    int tdiv = 3;
    int tcnt = 0;
    int cyc = 0;
    int n_valid = 0;
    bit run_chk = 1'b0;
    string tx_tag = "R2";
    string rx_tag = "R6";

    // behavioural model state
    bit        m_busy = 1'b0;
    int        m_idx = 0;
    int        m_cnt = 0;
    int        m_nb = 11;
    bit [11:0] m_bits = '1;
    logic [9:0] exp_q[$];

    assign rxd = loop_en ? txd : rxd_drv;

    always #(CLK_PERIOD/2) clk = ~clk;

    nine_bit_uart dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .tick         (tick),
        .tx_load      (tx_load),
        .tx_byte      (tx_byte),
        .tx_bit9      (tx_bit9),
        .two_stop     (two_stop),
        .txd          (txd),
        .tx_busy      (tx_busy),
        .rxd          (rxd),
        .rx_byte      (rx_byte),
        .rx_bit9      (rx_bit9),
        .rx_valid     (rx_valid),
        .rx_frame_err (rx_frame_err)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // tick generator, one pulse every tdiv clocks
    always @(negedge clk) begin
        tcnt = (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
        tick = (tcnt == 0);
    end

    // reference transmitter model, advanced on every clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 1'b0;
            m_idx  = 0;
            m_cnt  = 0;
        end else if (!m_busy) begin
            if (tx_load) begin
                m_busy = 1'b1;
                m_idx  = 0;
                m_cnt  = 0;
                m_nb   = two_stop ? 12 : 11;
                m_bits = '1;
                m_bits[0] = 1'b0;
                for (int i = 0; i < 8; i++) m_bits[i+1] = tx_byte[i];
                m_bits[9] = tx_bit9;
                if (loop_en) exp_q.push_back({1'b0, tx_bit9, tx_byte});
            end
        end else if (tick) begin
            if (m_cnt == 15) begin
                m_cnt = 0;
                m_idx++;
                if (m_idx == m_nb) m_busy = 1'b0;
            end else begin
                m_cnt++;
            end
        end
    end

    // per-clock comparison against the model and the expected receive queue
    always @(negedge clk) begin
        if (run_chk && rst_n) begin
            chk(tx_tag, "txd", {31'd0, txd}, {31'd0, (m_busy ? m_bits[m_idx] : 1'b1)});
            chk("R4", "tx_busy", {31'd0, tx_busy}, {31'd0, m_busy});
            if (rx_valid) begin
                n_valid++;
                if (exp_q.size() == 0) begin
                    chk(rx_tag, "unexpected rx_valid", 32'd1, 32'd0);
                end else begin
                    chk(rx_tag, "rx frame", {22'd0, rx_frame_err, rx_bit9, rx_byte},
                        {22'd0, exp_q.pop_front()});
                end
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_err++;
            $display("FAIL R4 watchdog: actual=%0d expected<%0d cycles", cyc, WD_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    task automatic send_tx(input logic [7:0] b, input logic b9);
        while (tx_busy) @(negedge clk);
        tx_byte = b;
        tx_bit9 = b9;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        while (tx_busy) @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    task automatic hold_ticks(input logic v, input int nt);
        rxd_drv = v;
        repeat (nt * tdiv) @(negedge clk);
    endtask

    task automatic send_raw(input logic [7:0] b, input logic b9, input logic stopv);
        hold_ticks(1'b0, 16);
        for (int i = 0; i < 8; i++) hold_ticks(b[i], 16);
        hold_ticks(b9, 16);
        hold_ticks(stopv, 16);
    endtask

    initial begin
        int base;
        // R1: reset values
        repeat (4) @(negedge clk);
        chk("R1", "txd in reset", {31'd0, txd}, 32'd1);
        chk("R1", "busy in reset", {31'd0, tx_busy}, 32'd0);
        chk("R1", "rx_valid in reset", {31'd0, rx_valid}, 32'd0);
        chk("R1", "frame_err in reset", {31'd0, rx_frame_err}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "txd after reset", {31'd0, txd}, 32'd1);
        chk("R1", "busy after reset", {31'd0, tx_busy}, 32'd0);
        run_chk = 1'b1;
        repeat (10) @(negedge clk);

        // R2 / R6: one stop bit, loopback
        tx_tag = "R2"; rx_tag = "R6";
        two_stop = 1'b0;
        send_tx(8'h00, 1'b1);
        send_tx(8'hA5, 1'b0);
        send_tx(8'hFF, 1'b1);
        send_tx(8'h3C, 1'b0);

        // R3 / R10: two stop bits
        tx_tag = "R3"; rx_tag = "R10";
        two_stop = 1'b1;
        send_tx(8'h5A, 1'b1);
        send_tx(8'h81, 1'b0);
        two_stop = 1'b0;

        // R2: different tick spacing
        tx_tag = "R2"; rx_tag = "R6";
        tdiv = 1;
        send_tx(8'hC3, 1'b1);
        tdiv = 5;
        send_tx(8'h17, 1'b0);
        tdiv = 3;

        // R5: load while busy is ignored
        tx_tag = "R5"; rx_tag = "R5";
        base = n_valid;
        tx_byte = 8'h66; tx_bit9 = 1'b1; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        repeat (40) @(negedge clk);
        tx_byte = 8'h99; tx_bit9 = 1'b0; tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        while (tx_busy) @(negedge clk);
        repeat (60) @(negedge clk);
        chk("R5", "frames delivered", n_valid - base, 32'd1);
        chk("R5", "busy stays low after frame", {31'd0, tx_busy}, 32'd0);

        // R7: false start with the loopback opened
        tx_tag = "R2"; rx_tag = "R7";
        rxd_drv = 1'b1;
        @(negedge clk);
        loop_en = 1'b0;
        hold_ticks(1'b1, 20);
        base = n_valid;
        hold_ticks(1'b0, 3);
        hold_ticks(1'b1, 200);
        chk("R7", "no frame on glitch", n_valid - base, 32'd0);

        // R8 / R9: stop bit low, then line held low
        rx_tag = "R8";
        base = n_valid;
        exp_q.push_back({1'b1, 1'b1, 8'h4E});
        send_raw(8'h4E, 1'b1, 1'b0);
        rx_tag = "R9";
        hold_ticks(1'b0, 200);
        chk("R8", "one frame with error", n_valid - base, 32'd1);
        chk("R8", "frame_err held", {31'd0, rx_frame_err}, 32'd1);
        hold_ticks(1'b1, 40);
        chk("R9", "no frame while held low", n_valid - base, 32'd1);

        // R8: clean frame clears the flag
        rx_tag = "R8";
        exp_q.push_back({1'b0, 1'b0, 8'hB2});
        send_raw(8'hB2, 1'b0, 1'b1);
        hold_ticks(1'b1, 20);
        chk("R8", "frame_err cleared", {31'd0, rx_frame_err}, 32'd0);
        chk("R8", "clean frame count", n_valid - base, 32'd2);

        chk("R6", "expected queue drained", exp_q.size(), 32'd0);
        run_chk = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule